// File: doc/BRIEF.md
# Link Debug Error Injection Unit

This block sits on the upstream path of a serial memory-channel buffer. It lets validation software provoke link faults on demand. Every downstream command is tested against a programmable mask and match value. A hit is a trigger event. If the matching injection mode is armed, the trigger does one of two things:

- It corrupts the check field of the next upstream frame. The frame's payload is left intact, so the receiver sees a transport error on that frame.
- It starts a forced alert sequence, timed after the upstream response slot of the triggering command. The injected cause is recorded in a sticky status bit.

Software can also replace the status block returned for a Sync command with a value it has written. It may also supply parity bits that are deliberately wrong, so that the host's parity checking can be tested.

Each injection mode fires once per arming. The upstream frame stream is passed through a single register stage. Software reaches the block through a small register file with separate write and read ports.

Top module: `lnk_err_inj`

## Requirements
- R1: A command with `cmd_valid` high is a hit when `(cmd_data ^ MATCH) & MASK == 0`. A hit sets status bit 2.
  - Register map (`reg_addr`): 0 = MASK, 1 = MATCH, 2 = CTRL, 3 = USER, 4 = STATUS. Other addresses read zero.
- R2: Writing CTRL bit 0 arms check-field corruption.
  - The next hit clears that bit.
  - The first valid upstream frame in a later cycle leaves with `nb_out_crc = nb_in_crc ^ P` and unchanged data. P is defined in R3.
  - That frame sets status bit 3.
  - Later frames pass unchanged until the mode is re-armed.
- R3: P is the low CRC_W bits of a 16-bit LFSR, replaced by 1 when those bits are all zero.
  - The LFSR loads 16'hACE1 in reset and steps on every clock after that.
  - Each step shifts left by one and feeds bit15^bit13^bit12^bit10 into bit 0 (polynomial x^16+x^14+x^13+x^11+1).
- R4: Writing CTRL bit 1 arms a forced alert. The next hit clears that bit.
  - `nb_alert` rises exactly RET_LAT+2 clocks after the edge that samples the hit, and stays high for ALERT_LEN clocks.
  - Status bit 0 is set at the edge where `nb_alert` rises.
- R5: A pulse on `crc_err_in` sets status bit 1 and leaves status bit 0 unchanged.
- R6: Status bits are sticky. Writing 1 to a bit of STATUS clears it, and writing 0 leaves it as it is.
- R7: Every Sync command (`cmd_valid` and `cmd_sync`) produces a one-cycle `sts_out_valid` pulse on the next clock.
  - If the previous Sync had `cmd_rsel == 2'b11`, the block carries USER[STAT_W-1:0].
  - Otherwise it carries `sts_live`.
  - The user value is used for that one block only.
- R8: Status parity is computed as `par[0]` = XOR of the even-indexed data bits and `par[1]` = XOR of the odd-indexed bits.
  - When a block carries the user value and USER bit STAT_W+2 (override enable) is set, USER[STAT_W+1:STAT_W] is sent verbatim instead, even when it is wrong.
- R9: After reset, all outputs are low and every register reads zero.
  - Upstream frames with no pending injection appear one clock later with data and check field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Decoded downstream command present |
| cmd_data | input | CMD_W | Command word compared under mask |
| cmd_sync | input | 1 | Command is a Sync |
| cmd_rsel | input | 2 | R field of a Sync command |
| nb_in_valid | input | 1 | Upstream frame present |
| nb_in_data | input | DATA_W | Upstream frame payload |
| nb_in_crc | input | CRC_W | Upstream frame check field |
| crc_err_in | input | 1 | Genuine check-field error detected |
| sts_live | input | STAT_W | Live status value |
| nb_out_valid | output | 1 | Upstream frame out |
| nb_out_data | output | DATA_W | Upstream payload out |
| nb_out_crc | output | CRC_W | Check field out, possibly corrupted |
| nb_alert | output | 1 | Forced alert in progress |
| sts_out_valid | output | 1 | Sync status block out |
| sts_out_data | output | STAT_W | Status block value |
| sts_out_par | output | 2 | Status block parity |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The bench mixes random masks, match values and commands with directed cases, and tests hit detection through the sticky trigger bit.

It counts the exact clock on which the alert rises and falls. A design off by one in the response-slot delay would raise the alert a clock early or late.

It checks that corruption hits only the one frame after the trigger. A unit that did not self-clear would corrupt every later frame, and one that corrupted the trigger cycle's own frame would miss the first check.

It walks the Sync override through arm, use and revert, with good and bad parity. A design that kept the override alive, or recomputed the user parity, would return the wrong status block.

// File: rtl/lnk_err_inj.sv
module lnk_err_inj #(
  parameter int CMD_W = 32,
  parameter int DATA_W = 64,
  parameter int CRC_W = 12,
  parameter int STAT_W = 16,
  parameter int RET_LAT = 4,
  parameter int ALERT_GAP = 2,
  parameter int ALERT_LEN = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              cmd_sync,
  input  logic [1:0]        cmd_rsel,
  input  logic              nb_in_valid,
  input  logic [DATA_W-1:0] nb_in_data,
  input  logic [CRC_W-1:0]  nb_in_crc,
  input  logic              crc_err_in,
  input  logic [STAT_W-1:0] sts_live,
  output logic              nb_out_valid,
  output logic [DATA_W-1:0] nb_out_data,
  output logic [CRC_W-1:0]  nb_out_crc,
  output logic              nb_alert,
  output logic              sts_out_valid,
  output logic [STAT_W-1:0] sts_out_data,
  output logic [1:0]        sts_out_par,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int DLY = RET_LAT + ALERT_GAP;
  localparam int DLY_W = $clog2(DLY + 1);
  localparam int LEN_W = $clog2(ALERT_LEN + 1);

  logic [CMD_W-1:0]  mask_q, match_q;
  logic              arm_crc, arm_alert;
  logic [STAT_W-1:0] usr_val;
  logic [1:0]        usr_par;
  logic              ovr_en, ovr_pend, crc_pend;
  logic [3:0]        st_q;
  logic [15:0]       lfsr;
  logic [DLY_W-1:0]  dly_cnt;
  logic [LEN_W-1:0]  alert_left;

  function automatic logic [1:0] par2(input logic [STAT_W-1:0] v);
    logic [1:0] p;
    p = 2'b00;
    for (int i = 0; i < STAT_W; i++) p[i % 2] = p[i % 2] ^ v[i];
    return p;
  endfunction

  wire hit        = cmd_valid && (((cmd_data ^ match_q) & mask_q) == '0);
  wire alert_idle = (dly_cnt == '0) && (alert_left == '0);
  wire crc_fire   = hit && arm_crc;
  wire alert_fire = hit && arm_alert && alert_idle;
  wire inject_now = crc_pend && nb_in_valid;
  wire alert_go   = (dly_cnt == DLY_W'(1));
  wire is_sync    = cmd_valid && cmd_sync;
  wire wr_ctrl    = reg_we && (reg_addr == 3'd2);
  wire lfsr_fb    = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
  wire [CRC_W-1:0] pat = (lfsr[CRC_W-1:0] == '0) ? CRC_W'(1) : lfsr[CRC_W-1:0];
  wire [3:0] st_set = {inject_now, hit, crc_err_in, alert_go};
  wire [STAT_W-1:0] sts_sel = ovr_pend ? usr_val : sts_live;

  assign nb_alert = (alert_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= LFSR_SEED;
      mask_q <= '0;
      match_q <= '0;
      arm_crc <= 1'b0;
      arm_alert <= 1'b0;
      usr_val <= '0;
      usr_par <= '0;
      ovr_en <= 1'b0;
      ovr_pend <= 1'b0;
      crc_pend <= 1'b0;
      st_q <= '0;
      dly_cnt <= '0;
      alert_left <= '0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr_fb};

      if (reg_we && reg_addr == 3'd0) mask_q <= reg_wdata[CMD_W-1:0];
      if (reg_we && reg_addr == 3'd1) match_q <= reg_wdata[CMD_W-1:0];
      if (reg_we && reg_addr == 3'd3) begin
        usr_val <= reg_wdata[STAT_W-1:0];
        usr_par <= reg_wdata[STAT_W+1:STAT_W];
        ovr_en  <= reg_wdata[STAT_W+2];
      end

      if (wr_ctrl) begin
        arm_crc   <= reg_wdata[0];
        arm_alert <= reg_wdata[1];
      end else begin
        if (crc_fire) arm_crc <= 1'b0;
        if (alert_fire) arm_alert <= 1'b0;
      end

      if (crc_fire) crc_pend <= 1'b1;
      else if (inject_now) crc_pend <= 1'b0;

      if (alert_fire) dly_cnt <= DLY_W'(DLY);
      else if (dly_cnt != '0) dly_cnt <= dly_cnt - 1'b1;

      if (alert_go) alert_left <= LEN_W'(ALERT_LEN);
      else if (alert_left != '0) alert_left <= alert_left - 1'b1;

      if (reg_we && reg_addr == 3'd4) st_q <= (st_q & ~reg_wdata[3:0]) | st_set;
      else st_q <= st_q | st_set;

      if (is_sync) ovr_pend <= (cmd_rsel == 2'b11);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nb_out_valid <= 1'b0;
      nb_out_data <= '0;
      nb_out_crc <= '0;
      sts_out_valid <= 1'b0;
      sts_out_data <= '0;
      sts_out_par <= '0;
    end else begin
      nb_out_valid <= nb_in_valid;
      nb_out_data <= nb_in_data;
      nb_out_crc <= nb_in_crc ^ (inject_now ? pat : '0);
      sts_out_valid <= is_sync;
      if (is_sync) begin
        sts_out_data <= sts_sel;
        sts_out_par <= (ovr_pend && ovr_en) ? usr_par : par2(sts_sel);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[CMD_W-1:0] = mask_q;
      3'd1: reg_rdata[CMD_W-1:0] = match_q;
      3'd2: reg_rdata[1:0] = {arm_alert, arm_crc};
      3'd3: reg_rdata[STAT_W+2:0] = {ovr_en, usr_par, usr_val};
      3'd4: reg_rdata[3:0] = st_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lnk_err_inj_chk.sv
module lnk_err_inj_chk #(
  parameter int DATA_W = 64,
  parameter int CRC_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_sync,
  input logic              nb_in_valid,
  input logic [DATA_W-1:0] nb_in_data,
  input logic [CRC_W-1:0]  nb_in_crc,
  input logic              nb_out_valid,
  input logic [DATA_W-1:0] nb_out_data,
  input logic [CRC_W-1:0]  nb_out_crc,
  input logic              nb_alert,
  input logic [3:0]        st_q,
  input logic              crc_pend,
  input logic              arm_crc,
  input logic              crc_fire,
  input logic              wr_ctrl,
  input logic              sts_out_valid,
  input logic [1:0]        sts_out_par,
  input logic              ovr_pend,
  input logic              ovr_en,
  input logic [1:0]        usr_par
);
  AST_CRC_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_out_valid && nb_out_crc != $past(nb_in_crc)) |-> $past(crc_pend && nb_in_valid)); // R2
  AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(crc_fire && !wr_ctrl) |-> !arm_crc); // R2
  AST_ALERT_MARKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nb_alert) |-> st_q[0]); // R4
  AST_STS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sts_out_valid |-> $past(cmd_valid && cmd_sync)); // R7
  AST_BAD_PAR_VERBATIM: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_out_valid && $past(ovr_pend && ovr_en)) |-> sts_out_par == $past(usr_par)); // R8
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    nb_out_valid |-> nb_out_data == $past(nb_in_data)); // R9
  AST_VALID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    nb_out_valid == $past(nb_in_valid)); // R9
endmodule

bind lnk_err_inj lnk_err_inj_chk #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sync(cmd_sync),
  .nb_in_valid(nb_in_valid), .nb_in_data(nb_in_data), .nb_in_crc(nb_in_crc),
  .nb_out_valid(nb_out_valid), .nb_out_data(nb_out_data), .nb_out_crc(nb_out_crc),
  .nb_alert(nb_alert), .st_q(st_q), .crc_pend(crc_pend), .arm_crc(arm_crc),
  .crc_fire(crc_fire), .wr_ctrl(wr_ctrl), .sts_out_valid(sts_out_valid),
  .sts_out_par(sts_out_par), .ovr_pend(ovr_pend), .ovr_en(ovr_en), .usr_par(usr_par)
);

// File: tb/lnk_err_inj_bench.sv
module lnk_err_inj_bench;
  localparam int CMD_W = 32, DATA_W = 64, CRC_W = 12, STAT_W = 16;
  localparam int RET_LAT = 4, ALERT_LEN = 4, DLY = RET_LAT + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_sync = 0, nb_in_valid = 0, crc_err_in = 0, reg_we = 0;
  logic [CMD_W-1:0] cmd_data = '0;
  logic [1:0] cmd_rsel = '0;
  logic [DATA_W-1:0] nb_in_data = '0;
  logic [CRC_W-1:0] nb_in_crc = '0;
  logic [STAT_W-1:0] sts_live = '0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic nb_out_valid, nb_alert, sts_out_valid;
  logic [DATA_W-1:0] nb_out_data;
  logic [CRC_W-1:0] nb_out_crc;
  logic [STAT_W-1:0] sts_out_data;
  logic [1:0] sts_out_par;
  logic [31:0] reg_rdata;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [15:0] m_lfsr;

  always #2 clk = ~clk;

  lnk_err_inj #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CRC_W(CRC_W), .STAT_W(STAT_W),
                .RET_LAT(RET_LAT), .ALERT_LEN(ALERT_LEN)) u_lnk_err_inj (.*);

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
  function automatic logic [CRC_W-1:0] pat_of(input logic [15:0] s);
    return (s[CRC_W-1:0] == '0) ? CRC_W'(1) : s[CRC_W-1:0];
  endfunction
  function automatic logic [1:0] par_of(input logic [STAT_W-1:0] v);
    logic [1:0] p = 2'b00;
    for (int i = 0; i < STAT_W; i++) p[i % 2] = p[i % 2] ^ v[i];
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_lfsr <= 16'hACE1;
    else m_lfsr <= lfsr_step(m_lfsr);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic send_cmd(input logic [31:0] d, input bit s, input logic [1:0] r);
    cmd_valid = 1; cmd_data = d; cmd_sync = s; cmd_rsel = r;
    tick();
    cmd_valid = 0; cmd_sync = 0;
  endtask

  task automatic frame(input logic [DATA_W-1:0] d, input logic [CRC_W-1:0] c, input bit corrupt, input string tag);
    logic [CRC_W-1:0] exp;
    exp = corrupt ? (c ^ pat_of(m_lfsr)) : c;
    nb_in_valid = 1; nb_in_data = d; nb_in_crc = c;
    tick();
    nb_in_valid = 0;
    chk(nb_out_valid && nb_out_crc == exp, tag, {52'd0, nb_out_crc}, {52'd0, exp});
    chk(nb_out_data == d, tag, nb_out_data, d);
  endtask

  task automatic sync_chk(input logic [1:0] r, input logic [STAT_W-1:0] ed, input logic [1:0] ep, input string tag);
    send_cmd(32'h0, 1'b1, r);
    chk(sts_out_valid && sts_out_data == ed, tag, {48'd0, sts_out_data}, {48'd0, ed});
    chk(sts_out_par == ep, tag, {62'd0, sts_out_par}, {62'd0, ep});
  endtask

  initial begin
    logic [31:0] v, mk, mt, cd;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R9 reset state
    chk(!nb_out_valid && !nb_alert && !sts_out_valid, "R9 reset outputs", {61'd0, nb_out_valid, nb_alert, sts_out_valid}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R9 reset regs", {32'd0, v}, 0);
    end

    // R1 random mask/match
    for (int i = 0; i < 40; i++) begin
      mk = $urandom; mt = $urandom; cd = $urandom;
      if (i % 2 == 0) cd = (mt & mk) | (cd & ~mk);
      wr(3'd0, mk); wr(3'd1, mt); wr(3'd4, 32'hF);
      send_cmd(cd, 1'b0, 2'b00);
      rd(3'd4, v);
      chk(v[2] == (((cd ^ mt) & mk) == 0), "R1 mask/match hit", {63'd0, v[2]}, {63'd0, (((cd ^ mt) & mk) == 0)});
    end

    // R9 random pass-through
    for (int i = 0; i < 20; i++) frame({$urandom, $urandom}, CRC_W'($urandom), 1'b0, "R9 passthrough");

    // R2/R3 CRC corruption
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hA5A5_0001); wr(3'd4, 32'hF);
    wr(3'd2, 32'h1);
    send_cmd(32'hA5A5_0002, 1'b0, 2'b00);
    frame(64'h1111_2222_3333_4444, 12'h5A5, 1'b0, "R1 no hit no corrupt");
    rd(3'd2, v);
    chk(v[0] == 1'b1, "R2 still armed after miss", {63'd0, v[0]}, 1);
    send_cmd(32'hA5A5_0001, 1'b0, 2'b00);
    rd(3'd2, v);
    chk(v[0] == 1'b0, "R2 arm self-clear", {63'd0, v[0]}, 0);
    frame(64'hDEAD_BEEF_0BAD_F00D, 12'h123, 1'b1, "R2 R3 corrupted frame");
    frame(64'hCAFE_0000_1234_5678, 12'h456, 1'b0, "R2 fires once");
    rd(3'd4, v);
    chk(v[3] == 1'b1 && v[0] == 1'b0, "R2 inject status", {60'd0, v[3:0]}, 64'h8 | {60'd0, v[2:0] & 3'b110});

    // R4 forced alert timing
    wr(3'd4, 32'hF);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h2);
    send_cmd(32'h1234_5678, 1'b0, 2'b00);
    for (int k = 0; k <= DLY + ALERT_LEN; k++) begin
      chk(nb_alert == (k >= DLY && k < DLY + ALERT_LEN), "R4 alert timing", {63'd0, nb_alert}, {63'd0, (k >= DLY && k < DLY + ALERT_LEN)});
      tick();
    end
    rd(3'd4, v);
    chk(v[0] == 1'b1 && v[1] == 1'b0, "R4 alert status bit", {62'd0, v[1:0]}, 1);
    rd(3'd2, v);
    chk(v[1] == 1'b0, "R4 arm self-clear", {63'd0, v[1]}, 0);

    // R5 genuine error, R6 W1C
    crc_err_in = 1; tick(); crc_err_in = 0;
    rd(3'd4, v);
    chk(v[1:0] == 2'b11, "R5 genuine error bit", {62'd0, v[1:0]}, 3);
    wr(3'd4, 32'h1);
    rd(3'd4, v);
    chk(v[1:0] == 2'b10, "R6 W1C clears only written bit", {62'd0, v[1:0]}, 2);
    wr(3'd4, 32'h0);
    rd(3'd4, v);
    chk(v[1:0] == 2'b10, "R6 write 0 keeps bit", {62'd0, v[1:0]}, 2);

    // R7/R8 Sync status override
    sts_live = 16'h1234;
    wr(3'd3, {13'd0, 1'b0, 2'b00, 16'hBEEF});
    sync_chk(2'b11, 16'h1234, par_of(16'h1234), "R7 arming sync returns live");
    sync_chk(2'b00, 16'hBEEF, par_of(16'hBEEF), "R7 R8 user value good parity");
    sync_chk(2'b00, 16'h1234, par_of(16'h1234), "R7 reverts to live");
    wr(3'd3, {13'd0, 1'b1, ~par_of(16'hBEEF), 16'hBEEF});
    sync_chk(2'b11, 16'h1234, par_of(16'h1234), "R7 arm again");
    sync_chk(2'b01, 16'hBEEF, ~par_of(16'hBEEF), "R8 bad parity verbatim");
    tick();
    chk(!sts_out_valid, "R7 one-cycle pulse", {63'd0, sts_out_valid}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule